// File: doc/BRIEF.md
# Three-Channel Match Timer

This peripheral holds three independent 32-bit counters behind a small word-addressed register bus. Each channel has a count, a reload value and two compare values. It counts up or down by one on each of its ticks. When it wraps past its end value, it takes the reload value as its new count and flags an overflow. When its new count equals either compare value, it flags a match. Software can read the count while the channel runs, so a free-running channel serves as a time base. A channel loaded with all-ones minus (P - 1) in both count and reload overflows once every P ticks.

One shared control word holds four settings per channel: an enable, a clock-source select, an interrupt enable and the count direction. The clock source is either every cycle of the bus clock or each rising edge of an external tick input. That input is first brought into the clock domain through two flip-flops. There are nine event sources, three per channel. They collect in a shared sticky status word that is cleared by writing 1 to a bit. A shared mask word blocks sources, and a single interrupt line combines the sources that are not blocked.

The bus has no handshake. A write takes effect at the clock edge on which `bus_wr` is high. Read data depends combinationally on `bus_addr`, so it is valid in the same cycle as the address. The block has no data stream, so it has no valid/ready interface and no back-pressure.

Top module: `tri_match_timer`

## Requirements
- R1: After reset, every count, reload and compare register, the control word and the status word read 0. The mask word reads 0x1FF and `irq` is low.
- R2: The register map uses word indices, where the index is the byte offset divided by 4.
  - Channel n uses indices 4n to 4n+3: 4n is the count, 4n+1 the reload value, 4n+2 compare A and 4n+3 compare B.
  - Index 12 is the control word, 13 the status word and 14 the mask word.
  - Written values read back unchanged, and index 15 reads 0.
- R3: Control bit 3n enables channel n, and control bit 9+n set to 1 makes it count up. In bus-clock mode (control bit 3n+1 = 0), an enabled channel changes its count by one on every clock edge. Counting starts at the first edge after the edge that writes the enable, and it also counts at the edge that writes the disable.
- R4: A down-counting channel (bit 9+n = 0) whose count is 0 takes the reload value on its next tick, and that tick sets status bit 3n+2.
- R5: An up-counting channel whose count is 0xFFFFFFFF takes the reload value on its next tick, and that tick sets status bit 3n+2.
- R6: A channel whose enable bit is 0 holds its count.
- R7: A tick that moves the count of channel n to its compare A value sets status bit 3n. A tick that moves it to its compare B value sets status bit 3n+1. Status bits stay set until they are cleared.
- R8: Writing the status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R9: `irq` is high exactly when some status bit is 1, its mask bit is 0, and the interrupt enable of its channel (control bit 3n+2) is 1.
- R10: With control bit 3n+1 = 1, the channel counts once for each rising edge of `ext_clk`, after two synchronizing flip-flops. It does not count on bus-clock cycles that have no such edge. Each level of `ext_clk` must be held for at least two clock cycles.
- R11: A bus write to a channel's count wins over a tick of that channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External tick input, asynchronous to `clk` |
| bus_wr | input | 1 | Write strobe; the write lands at this clock edge |
| bus_addr | input | 4 | Word index of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
Each result is due at a known cycle:

- A register write is visible at the next sampling point.
- A bus-clock channel moves once per edge. The first move is at the edge after its enable is written, and the last is at the edge that writes its disable. A run of N idle cycles between those two writes therefore yields N+1 steps.
- An external edge reaches the count at the third clock edge after `ext_clk` rises.
- Status bits and `irq` follow the same edge that moves the count.

Every action of the bench starts one nanosecond after a rising edge. The driver queues each expected value. The monitor compares it at the following falling edge, when bus-clock channels are stopped or have a fixed number of counted edges behind them.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_CH     = 3;
  localparam int SRC_PER_CH = 3;
  localparam int NUM_SRC    = NUM_CH * SRC_PER_CH;
  localparam int CTRL_W     = NUM_CH * 4;
  localparam int ADDR_W     = 4;
  localparam int FIELDS     = 4;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] IDX_CTRL = ADDR_W'(NUM_CH * FIELDS);
  localparam logic [ADDR_W-1:0] IDX_STAT = ADDR_W'(NUM_CH * FIELDS + 1);
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'(NUM_CH * FIELDS + 2);

  localparam logic [1:0] FLD_COUNT  = 2'd0;
  localparam logic [1:0] FLD_RELOAD = 2'd1;
  localparam logic [1:0] FLD_CMPA   = 2'd2;
  localparam logic [1:0] FLD_CMPB   = 2'd3;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[LAST-1:0], async_in};
  end

  assign rise_pulse = chain_q[LAST-1] & ~chain_q[LAST];

  p_tick_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         use_ext,
  input  logic         count_up,
  input  logic         ext_tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_fld,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] reload_q,
  output logic [W-1:0] cmpa_q,
  output logic [W-1:0] cmpb_q,
  output logic         ev_cmpa,
  output logic         ev_cmpb,
  output logic         ev_wrap
);
  logic         tick;
  logic         cnt_wr;
  logic         advance;
  logic         at_end;
  logic [W-1:0] cnt_next;

  assign tick    = run_en & (use_ext ? ext_tick : 1'b1);
  assign cnt_wr  = wr_en && (wr_fld == FLD_COUNT);
  assign advance = tick && !cnt_wr;
  assign at_end  = count_up ? (cnt_q == {W{1'b1}}) : (cnt_q == '0);

  always_comb begin
    if (at_end)        cnt_next = reload_q;
    else if (count_up) cnt_next = cnt_q + 1'b1;
    else               cnt_next = cnt_q - 1'b1;
  end

  assign ev_wrap = advance && at_end;
  assign ev_cmpa = advance && (cnt_next == cmpa_q);
  assign ev_cmpb = advance && (cnt_next == cmpb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      cmpa_q   <= '0;
      cmpb_q   <= '0;
    end else begin
      if (cnt_wr)       cnt_q <= wdata;
      else if (advance) cnt_q <= cnt_next;
      if (wr_en && wr_fld == FLD_RELOAD) reload_q <= wdata;
      if (wr_en && wr_fld == FLD_CMPA)   cmpa_q   <= wdata;
      if (wr_en && wr_fld == FLD_CMPB)   cmpb_q   <= wdata;
    end
  end

  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cnt_wr) |=> cnt_q == $past(cnt_q));

  p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && count_up && cnt_q != {W{1'b1}}) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_down_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && !count_up && cnt_q == '0) |=> cnt_q == $past(reload_q));

  p_up_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr && count_up && cnt_q == {W{1'b1}}) |=> cnt_q == $past(reload_q));

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(wdata));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl import tmr_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_ev,
  input  logic               wr_stat,
  input  logic               wr_mask,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_CH-1:0]  ch_ie,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               irq
);
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] ie_vec;

  assign clr_vec = wr_stat ? wdata : '0;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ie
      assign ie_vec[g*SRC_PER_CH +: SRC_PER_CH] = {SRC_PER_CH{ch_ie[g]}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr_vec) | set_ev;
      if (wr_mask) mask_q <= wdata;
    end
  end

  assign irq = |(status_q & ~mask_q & ie_vec);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> (status_q & $past(wdata & ~set_ev)) == '0);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> (status_q & $past(status_q)) == $past(status_q));

  p_mask_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  p_ie_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ie == '0) |-> !irq);
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer import tmr_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic               ext_tick;
  logic [NUM_SRC-1:0] set_ev;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_CH-1:0]  ch_en, ch_ext, ch_ie, ch_up;
  logic [CNT_W-1:0]   rd_cnt [NUM_CH];
  logic [CNT_W-1:0]   rd_rel [NUM_CH];
  logic [CNT_W-1:0]   rd_ca  [NUM_CH];
  logic [CNT_W-1:0]   rd_cb  [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             ctrl_q <= '0;
    else if (bus_wr && bus_addr == IDX_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise_pulse(ext_tick)
  );

  genvar n;
  generate
    for (n = 0; n < NUM_CH; n++) begin : g_ch
      assign ch_en[n]  = ctrl_q[SRC_PER_CH*n];
      assign ch_ext[n] = ctrl_q[SRC_PER_CH*n+1];
      assign ch_ie[n]  = ctrl_q[SRC_PER_CH*n+2];
      assign ch_up[n]  = ctrl_q[NUM_SRC+n];

      tmr_channel #(.W(CNT_W)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (ch_en[n]),
        .use_ext  (ch_ext[n]),
        .count_up (ch_up[n]),
        .ext_tick (ext_tick),
        .wr_en    (bus_wr && bus_addr[ADDR_W-1:2] == 2'(n)),
        .wr_fld   (bus_addr[1:0]),
        .wdata    (bus_wdata),
        .cnt_q    (rd_cnt[n]),
        .reload_q (rd_rel[n]),
        .cmpa_q   (rd_ca[n]),
        .cmpb_q   (rd_cb[n]),
        .ev_cmpa  (set_ev[SRC_PER_CH*n]),
        .ev_cmpb  (set_ev[SRC_PER_CH*n+1]),
        .ev_wrap  (set_ev[SRC_PER_CH*n+2])
      );
    end
  endgenerate

  tmr_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ev   (set_ev),
    .wr_stat  (bus_wr && bus_addr == IDX_STAT),
    .wr_mask  (bus_wr && bus_addr == IDX_MASK),
    .wdata    (bus_wdata[NUM_SRC-1:0]),
    .ch_ie    (ch_ie),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr[ADDR_W-1:2] == 2'(c)) begin
        case (bus_addr[1:0])
          FLD_COUNT:  bus_rdata = rd_cnt[c];
          FLD_RELOAD: bus_rdata = rd_rel[c];
          FLD_CMPA:   bus_rdata = rd_ca[c];
          default:    bus_rdata = rd_cb[c];
        endcase
      end
    end
    if (bus_addr == IDX_CTRL) bus_rdata = CNT_W'(ctrl_q);
    if (bus_addr == IDX_STAT) bus_rdata = CNT_W'(status_q);
    if (bus_addr == IDX_MASK) bus_rdata = CNT_W'(mask_q);
  end

  p_irq_needs_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0));
endmodule

// File: tb/sim_tri_match_timer.sv
module sim_tri_match_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  tri_match_timer u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = it.is_irq ? {31'd0, irq} : bus_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
      end
    end
  end

  // all tasks start and end 1 ns after a rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(1);

    // R1 reset values
    exp_rd(4'd0,  32'h0,   "R1 count0");
    exp_rd(4'd9,  32'h0,   "R1 reload2");
    exp_rd(4'd12, 32'h0,   "R1 ctrl");
    exp_rd(4'd13, 32'h0,   "R1 status");
    exp_rd(4'd14, 32'h1FF, "R1 mask");
    exp_irq(1'b0,          "R1 irq");

    // R2 map and readback
    wr(4'd11, 32'hA5A5_0001);
    exp_rd(4'd11, 32'hA5A5_0001, "R2 cmpB ch2");
    wr(4'd5, 32'h0000_1234);
    exp_rd(4'd5, 32'h0000_1234, "R2 reload ch1");
    exp_rd(4'd15, 32'h0, "R2 unmapped");

    // R5 up wrap on ch0: FD -> FE,FF,100,101,102
    wr(4'd0, 32'hFFFF_FFFD);
    wr(4'd1, 32'h0000_0100);
    wr(4'd12, 32'h201);
    idle(4);
    wr(4'd12, 32'h200);
    exp_rd(4'd0, 32'h0000_0102, "R5 R3 count after wrap");
    exp_rd(4'd13, 32'h004, "R5 wrap status");

    // R4 down wrap on ch1: 2 -> 1,0,50,4F,4E
    wr(4'd6, 32'h1000);
    wr(4'd7, 32'h2000);
    wr(4'd4, 32'h2);
    wr(4'd5, 32'h50);
    wr(4'd12, 32'h008);
    idle(4);
    wr(4'd12, 32'h000);
    exp_rd(4'd4, 32'h4E, "R4 count after down wrap");
    exp_rd(4'd13, 32'h024, "R4 wrap status");

    // R6 disabled ch0 held
    exp_rd(4'd0, 32'h0000_0102, "R6 hold ch0");

    // R7 compare on ch2: 0 -> 6, cmpA=3 hit, cmpB=0x40 missed
    wr(4'd8, 32'h0);
    wr(4'd9, 32'h0);
    wr(4'd10, 32'h3);
    wr(4'd11, 32'h40);
    wr(4'd12, 32'h841);
    idle(5);
    wr(4'd12, 32'h000);
    exp_rd(4'd8, 32'h6, "R7 R3 count ch2");
    exp_rd(4'd13, 32'h064, "R7 compare status");

    // R8 write-1-to-clear
    wr(4'd13, 32'h020);
    exp_rd(4'd13, 32'h044, "R8 clear one bit");
    wr(4'd13, 32'h000);
    exp_rd(4'd13, 32'h044, "R8 zero write no effect");

    // R9 interrupt combine
    exp_irq(1'b0, "R9 all masked");
    wr(4'd14, 32'h000);
    exp_irq(1'b0, "R9 no enable");
    wr(4'd12, 32'h004);
    exp_irq(1'b1, "R9 ch0 enabled");
    wr(4'd14, 32'h004);
    exp_irq(1'b0, "R9 ch0 masked");
    wr(4'd12, 32'h104);
    exp_irq(1'b1, "R9 ch2 enabled");
    wr(4'd13, 32'h040);
    exp_irq(1'b0, "R9 after clear");
    exp_rd(4'd13, 32'h004, "R9 status left");

    // R11 count write wins over tick
    wr(4'd12, 32'h201);
    wr(4'd0, 32'h1000);
    wr(4'd12, 32'h000);
    exp_rd(4'd0, 32'h1001, "R11 write priority");

    // R10 external tick on ch1
    wr(4'd4, 32'h0);
    wr(4'd12, 32'h418);
    idle(6);
    exp_rd(4'd4, 32'h0, "R10 no ext edges");
    for (int k = 0; k < 4; k++) begin
      ext_clk = 1'b1; idle(3);
      ext_clk = 1'b0; idle(3);
    end
    wr(4'd12, 32'h000);
    exp_rd(4'd4, 32'h4, "R10 ext edges counted");

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule